// File: doc/BRIEF.md
# Cascadable Binary Up-Counter with Phase-Gated Carry

The block is a W-bit binary up-counter (four bits by default). Two enables must both be high for it to count. Four active-low controls act on it: an immediate clear, an immediate load of the parallel input, a clocked clear, and a clocked load. The count appears on a bus that floats to high impedance when the active-low output enable is high. The output enable has no effect on the stored count.

Two carry outputs let several counters be chained into a wider counter. The ripple carry is combinational and is high when the chain enable is high and the count is at its maximum. The clock-phase carry is the ripple carry qualified by the count enable and by the low phase of the clock. It therefore cannot pulse while the clock is high. Either carry can drive the chain enable of the next stage. The ripple carry gives the shorter path from edge to enable.

Top module: `cascade_counter`

## Requirements
- R1: While `clr_now_n` is low the count reads zero at once, with no clock edge. This holds even when `load_now_n` is also low, and it overrides every other control.
- R2: While `load_now_n` is low (and `clr_now_n` is high) the count equals `par_in` at once, with no clock edge, and it stays equal to it across clock edges.
- R3: With both immediate controls high, a low `clr_sync_n` at a rising clock edge sets the count to zero. This wins over `load_sync_n` and over counting. The count does not change before that edge.
- R4: With `clr_sync_n` high, a low `load_sync_n` at a rising clock edge stores `par_in`. The count does not change before that edge.
- R5: With all four controls high and both `cnt_en` and `chain_en` high, each rising edge adds one to the count. The maximum value (all ones, 15 by default) wraps to 0.
- R6: With all four controls high, a low `cnt_en` or a low `chain_en` keeps the count unchanged across rising edges.
- R7: When `out_en_n` is high every bit of `q_bus` is high impedance. When it is low, `q_bus` carries the count. The count keeps advancing while the bus floats.
- R8: `carry_ripple` is high exactly when `chain_en` is high and the count is all ones.
- R9: `carry_clk` is high only while `clk` is low, `carry_ripple` is high and `cnt_en` is high. At all other times it is low.
- R10: Two stages, where the upper stage's `chain_en` is driven by the lower stage's `carry_ripple` and the enables are shared, form a 2W-bit counter that counts through every value and wraps.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; clocked operations act on its rising edge |
| clr_now_n | input | 1 | Immediate clear, active low, highest priority |
| load_now_n | input | 1 | Immediate level-sensitive load of `par_in`, active low |
| clr_sync_n | input | 1 | Clocked clear, active low |
| load_sync_n | input | 1 | Clocked load of `par_in`, active low |
| cnt_en | input | 1 | Count enable; also qualifies `carry_clk` |
| chain_en | input | 1 | Chain enable; also qualifies both carries |
| out_en_n | input | 1 | Output enable for `q_bus`, active low |
| par_in | input | W | Parallel load data |
| q_bus | output | W | Count, or high impedance |
| carry_ripple | output | 1 | Combinational terminal-count carry |
| carry_clk | output | 1 | Carry gated to the clock's low phase |

## Verification
A free-running sweep over more than two full wraps compares each count with a modular expectation computed in the bench. On every cycle it also checks both carries: the ripple carry in the high phase of the clock and the clock-phase carry in the low phase. This separates a correct terminal-count decode from one that is off by one or ignores the clock phase. Priority patterns drive conflicting controls together: immediate clear with immediate load, and clocked clear with clocked load. Reads taken between clock edges separate immediate actions from clocked ones. Enable patterns lower each enable alone at the terminal count, which shows which enable qualifies which carry. A two-stage cascade then runs through all 256 combined values and past the wrap.

// File: rtl/cascade_counter.sv
module cascade_counter #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         clr_now_n,
  input  logic         load_now_n,
  input  logic         clr_sync_n,
  input  logic         load_sync_n,
  input  logic         cnt_en,
  input  logic         chain_en,
  input  logic         out_en_n,
  input  logic [W-1:0] par_in,
  output wire  [W-1:0] q_bus,
  output logic         carry_ripple,
  output logic         carry_clk
);
  localparam logic [W-1:0] TOP = {W{1'b1}};

  logic [W-1:0] cnt_q;
  logic [W-1:0] cur;

  always_ff @(posedge clk or negedge clr_now_n or negedge load_now_n) begin
    if (!clr_now_n)                cnt_q <= '0;
    else if (!load_now_n)          cnt_q <= par_in;
    else if (!clr_sync_n)          cnt_q <= '0;
    else if (!load_sync_n)         cnt_q <= par_in;
    else if (cnt_en && chain_en)   cnt_q <= cnt_q + 1'b1;
  end

  assign cur          = !clr_now_n ? '0 : (!load_now_n ? par_in : cnt_q);
  assign q_bus        = out_en_n ? {W{1'bz}} : cur;
  assign carry_ripple = chain_en & (cur == TOP);
  assign carry_clk    = carry_ripple & cnt_en & ~clk;
endmodule

// File: rtl/cascade_counter_chk.sv
module cascade_counter_chk #(
  parameter int W = 4
) (
  input logic         clk,
  input logic         clr_now_n,
  input logic         load_now_n,
  input logic         clr_sync_n,
  input logic         load_sync_n,
  input logic         cnt_en,
  input logic         chain_en,
  input logic [W-1:0] par_in,
  input logic [W-1:0] cnt_q,
  input logic         carry_ripple,
  input logic         carry_clk
);
  // R1: a released immediate clear leaves the register at zero
  a_r1_clear_holds: assert property (@(posedge clk) disable iff (!clr_now_n)
    $rose(clr_now_n) |-> (cnt_q == '0) || !load_now_n);

  a_r3_sync_clear: assert property (@(posedge clk) disable iff (!clr_now_n)
    (load_now_n && !clr_sync_n) |=> (cnt_q == '0));

  a_r4_sync_load: assert property (@(posedge clk) disable iff (!clr_now_n)
    (load_now_n && clr_sync_n && !load_sync_n) |=> (cnt_q == $past(par_in)));

  a_r5_increment: assert property (@(posedge clk) disable iff (!clr_now_n)
    (load_now_n && clr_sync_n && load_sync_n && cnt_en && chain_en)
    |=> (cnt_q == W'($past(cnt_q) + 1'b1)));

  a_r8_ripple_needs_chain: assert property (@(posedge clk) disable iff (!clr_now_n)
    carry_ripple |-> chain_en);

  a_r9_clk_carry_low_phase: assert property (@(negedge clk) disable iff (!clr_now_n)
    !carry_clk);
endmodule

bind cascade_counter cascade_counter_chk #(.W(W)) chk_i (
  .clk(clk), .clr_now_n(clr_now_n), .load_now_n(load_now_n),
  .clr_sync_n(clr_sync_n), .load_sync_n(load_sync_n), .cnt_en(cnt_en),
  .chain_en(chain_en), .par_in(par_in), .cnt_q(cnt_q),
  .carry_ripple(carry_ripple), .carry_clk(carry_clk)
);

// File: tb/cascade_counter_tb_top.sv
module cascade_counter_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int W = 4;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic clr_now_n = 1'b0, load_now_n = 1'b1, clr_sync_n = 1'b1, load_sync_n = 1'b1;
  logic cnt_en = 1'b0, chain_en = 1'b0, out_en_n = 1'b0;
  logic [W-1:0] par_in = '0;
  wire  [W-1:0] q_bus;
  wire  carry_ripple, carry_clk;

  cascade_counter #(.W(W)) dut_i (
    .clk(clk), .clr_now_n(clr_now_n), .load_now_n(load_now_n),
    .clr_sync_n(clr_sync_n), .load_sync_n(load_sync_n), .cnt_en(cnt_en),
    .chain_en(chain_en), .out_en_n(out_en_n), .par_in(par_in),
    .q_bus(q_bus), .carry_ripple(carry_ripple), .carry_clk(carry_clk)
  );

  logic c_clr_n = 1'b0, c_en = 1'b0;
  wire [W-1:0] lo_q, hi_q;
  wire lo_rco, lo_cco, hi_rco, hi_cco;

  cascade_counter #(.W(W)) c_lo_i (
    .clk(clk), .clr_now_n(c_clr_n), .load_now_n(1'b1), .clr_sync_n(1'b1),
    .load_sync_n(1'b1), .cnt_en(c_en), .chain_en(c_en), .out_en_n(1'b0),
    .par_in('0), .q_bus(lo_q), .carry_ripple(lo_rco), .carry_clk(lo_cco)
  );
  cascade_counter #(.W(W)) c_hi_i (
    .clk(clk), .clr_now_n(c_clr_n), .load_now_n(1'b1), .clr_sync_n(1'b1),
    .load_sync_n(1'b1), .cnt_en(c_en), .chain_en(lo_rco), .out_en_n(1'b0),
    .par_in('0), .q_bus(hi_q), .carry_ripple(hi_rco), .carry_clk(hi_cco)
  );

  int n_tests = 0;
  int n_fail  = 0;

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  logic [W-1:0] e;

  initial begin
    #(CLK_PERIOD*20000);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    // R1: clear is immediate and beats the immediate load
    #2;
    chk("R1 reset", 16'(q_bus), 16'h0);
    par_in = 4'hA; load_now_n = 1'b0; #1;
    chk("R1 clear over load", 16'(q_bus), 16'h0);
    load_now_n = 1'b1;
    tick();
    clr_now_n = 1'b1; #1;
    chk("R1 after release", 16'(q_bus), 16'h0);

    // R2: immediate load, no clock needed, held across an edge
    par_in = 4'h9; load_now_n = 1'b0; #1;
    chk("R2 immediate load", 16'(q_bus), 16'h9);
    tick();
    chk("R2 held over edge", 16'(q_bus), 16'h9);
    load_now_n = 1'b1; #1;
    chk("R2 after release", 16'(q_bus), 16'h9);

    // R4: clocked load waits for the edge
    par_in = 4'h5; load_sync_n = 1'b0; #1;
    chk("R4 before edge", 16'(q_bus), 16'h9);
    tick();
    chk("R4 after edge", 16'(q_bus), 16'h5);

    // R3: clocked clear wins over clocked load and counting
    par_in = 4'h7; clr_sync_n = 1'b0; cnt_en = 1'b1; chain_en = 1'b1; #1;
    chk("R3 before edge", 16'(q_bus), 16'h5);
    tick();
    chk("R3 clear wins", 16'(q_bus), 16'h0);
    clr_sync_n = 1'b1; load_sync_n = 1'b1;

    // R5, R8, R9: free-running sweep across two wraps
    e = '0;
    for (int i = 0; i < 36; i++) begin
      tick();
      e = e + 1'b1;
      chk("R5 count", 16'(q_bus), 16'(e));
      chk("R8 ripple", 16'(carry_ripple), 16'(e == 4'hF));
      chk("R9 clk carry in high phase", 16'(carry_clk), 16'h0);
      #6;
      chk("R9 clk carry in low phase", 16'(carry_clk), 16'(e == 4'hF));
    end

    // R6: either enable low holds the count
    cnt_en = 1'b0;
    for (int i = 0; i < 3; i++) begin
      tick();
      chk("R6 count enable low", 16'(q_bus), 16'(e));
    end
    cnt_en = 1'b1; chain_en = 1'b0;
    for (int i = 0; i < 3; i++) begin
      tick();
      chk("R6 chain enable low", 16'(q_bus), 16'(e));
    end

    // R8, R9: enable qualification at terminal count
    cnt_en = 1'b0; par_in = 4'hF; load_sync_n = 1'b0;
    tick();
    load_sync_n = 1'b1; chain_en = 1'b1; #6;
    chk("R8 ripple at max", 16'(carry_ripple), 16'h1);
    chk("R9 no clk carry without count enable", 16'(carry_clk), 16'h0);
    tick();
    chain_en = 1'b0; #6;
    chk("R8 ripple off without chain enable", 16'(carry_ripple), 16'h0);
    chk("R9 no clk carry without chain enable", 16'(carry_clk), 16'h0);
    tick();
    chain_en = 1'b1; cnt_en = 1'b1; #6;
    chk("R9 clk carry both enables", 16'(carry_clk), 16'h1);

    // R5 wrap, R7: bus floats, count continues
    tick();
    chk("R5 wrap to zero", 16'(q_bus), 16'h0);
    out_en_n = 1'b1; #1;
    chk("R7 high impedance", 16'(q_bus === 4'bzzzz), 16'h1);
    tick(); tick(); tick();
    chk("R7 still floating", 16'(q_bus === 4'bzzzz), 16'h1);
    out_en_n = 1'b0; #1;
    chk("R7 count advanced while floating", 16'(q_bus), 16'h3);

    // R1: immediate clear in the middle of a cycle
    cnt_en = 1'b0;
    tick();
    clr_now_n = 1'b0; #1;
    chk("R1 mid-cycle clear", 16'(q_bus), 16'h0);
    clr_now_n = 1'b1; #1;
    chk("R1 clear sticks", 16'(q_bus), 16'h0);

    // R10: two-stage cascade through all 256 values
    c_clr_n = 1'b1; c_en = 1'b1;
    for (int i = 1; i <= 300; i++) begin
      tick();
      chk("R10 cascade", {8'h0, hi_q, lo_q}, 16'(i % 256));
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule